// File: doc/BRIEF.md
# Configuration Access Router

This block sits between a host I/O port and the configuration registers of a chip. The host first writes a full 32-bit word to an address port. That word selects a bus, a device, a function and a DWord register and carries an enable bit. Each later read or write to the companion data port becomes one configuration read or write aimed at that location. The byte enables of the host pick lanes inside the selected DWord. Only this address-plus-data-window scheme is decoded; there is no second access scheme.

Bus 0 is logical. Devices 0 and 1 on it are answered internally, through two register-file ports that share one payload and each have their own strobe. Any other bus/device pair goes to one downstream request port with a type flag: type 0 for bus 0 and type 1 for every other bus. That port holds the request until it is acknowledged. The host sees one acknowledge pulse per access, with the read data in the same cycle.

Top module: `cfg_access_router`

## Requirements
- R1: The address register loads only on a host write to byte port 0xCF8 with all four byte enables set. A write there with any byte enable clear changes nothing.
- R2: A read of port 0xCF8 returns the stored word: bit 31 enable, bits 23:16 bus, bits 15:11 device, bits 10:8 function, bits 7:2 register, and zero in bits 30:24 and 1:0.
- R3: While the stored enable bit is 0, an access to the data port 0xCFC returns 0xFFFFFFFF on a read, drops a write, and raises no request on any target port.
- R4: With enable set, bus 0 and device 0 or 1, a data-port access goes to the register-file port of that device, with the function, register (address bits 7:2), write flag and data taken from the address register and the host. Reads return that device's data.
- R5: The host byte enables reach the selected target unchanged, so a write changes only the enabled byte lanes of the DWord.
- R6: An access to a function of device 0 or 1 that its implemented-function mask (default: function 0 only) leaves out returns 0xFFFFFFFF on a read, drops a write, and raises no request.
- R7: Every other enabled data-port access is forwarded downstream with its bus, device, function, register, byte enables, data and write flag. The type flag is 0 when the bus is 0 and 1 otherwise. Device 0 or 1 on bus 0 is never forwarded.
- R8: A forwarded request stays asserted with a stable payload until the downstream acknowledge. The host acknowledge follows that cycle, and a read returns the downstream data.
- R9: The host acknowledge is a one-cycle pulse and at most one target request is active. It comes 1 cycle after the request for address-port, all-ones or dropped accesses and 3 cycles after it for internal devices. For downstream accesses it comes 1 cycle after the downstream acknowledge.
- R10: An access to any other I/O port returns 0xFFFFFFFF on a read and has no effect on a write. Write acknowledges always carry zero data.
- R11: After reset all outputs are low and the address register reads as zero, so data-port accesses start out disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hst_req | input | 1 | Host access strobe, one cycle |
| hst_we | input | 1 | Host write (1) or read (0) |
| hst_dw_addr | input | HAW-2 | Host I/O DWord address (byte address bits HAW-1:2) |
| hst_be | input | 4 | Host byte enables |
| hst_wdata | input | 32 | Host write data |
| hst_ack | output | 1 | Access complete pulse |
| hst_rdata | output | 32 | Read data, valid with hst_ack |
| rf0_req | output | 1 | Device 0 register-file strobe |
| rf1_req | output | 1 | Device 1 register-file strobe |
| rf_we | output | 1 | Register-file write flag |
| rf_func | output | 3 | Register-file function number |
| rf_reg | output | 6 | Register-file DWord register index |
| rf_be | output | 4 | Register-file byte enables |
| rf_wdata | output | 32 | Register-file write data |
| rf0_rdata | input | 32 | Device 0 read data, one cycle after the strobe |
| rf1_rdata | input | 32 | Device 1 read data, one cycle after the strobe |
| ds_req | output | 1 | Downstream request, held until ds_ack |
| ds_we | output | 1 | Downstream write flag |
| ds_type1 | output | 1 | 1 for a bus other than 0 |
| ds_bus | output | 8 | Downstream bus number |
| ds_dev | output | 5 | Downstream device number |
| ds_func | output | 3 | Downstream function number |
| ds_reg | output | 6 | Downstream DWord register index |
| ds_be | output | 4 | Downstream byte enables |
| ds_wdata | output | 32 | Downstream write data |
| ds_ack | input | 1 | Downstream completion |
| ds_rdata | input | 32 | Downstream read data, valid with ds_ack |

## Verification
The assertions assume that the host never raises a new strobe before the previous access has been acknowledged. They also assume that ds_ack rises only while ds_req is high, and that register-file read data is valid one cycle after its strobe. The bench keeps to these rules: its host task waits for each acknowledge, its downstream model acknowledges only a pending request after a fixed wait, and its register-file models are registered memories. Under these rules the assertions check routing exclusivity, request holding and the silence of disabled accesses.

// File: rtl/cfg_router_pkg.sv
package cfg_router_pkg;
  localparam int DW     = 32;
  localparam int BE_W   = DW / 8;
  localparam int BUS_W  = 8;
  localparam int DEV_W  = 5;
  localparam int FUNC_W = 3;
  localparam int REG_W  = 6;
  localparam int NFUNC  = 1 << FUNC_W;
  localparam int NINT   = 2;

  typedef struct packed {
    logic              en;
    logic [BUS_W-1:0]  bus;
    logic [DEV_W-1:0]  dev;
    logic [FUNC_W-1:0] func;
    logic [REG_W-1:0]  regn;
  } cfg_addr_t;

  typedef enum logic [2:0] {
    TGT_ADDR,
    TGT_ONES,
    TGT_DEV0,
    TGT_DEV1,
    TGT_DOWN
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RF_ISSUE,
    ST_RF_CAPT,
    ST_DS_WAIT
  } st_e;
endpackage

// File: rtl/cfg_addr_reg.sv
module cfg_addr_reg
  import cfg_router_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      wr_en,
  input  cfg_addr_t wr_val,
  output cfg_addr_t cur,
  output logic [DW-1:0] rd_view
);
  always_ff @(posedge clk) begin
    if (rst)        cur <= '0;
    else if (wr_en) cur <= wr_val;
  end

  // reserved bits read as zero
  assign rd_view = {cur.en, 7'b0, cur.bus, cur.dev, cur.func, cur.regn, 2'b00};
endmodule

// File: rtl/cfg_target_decode.sv
module cfg_target_decode
  import cfg_router_pkg::*;
#(
  parameter logic [NINT*NFUNC-1:0] INT_FUNCS = {8'h01, 8'h01}
) (
  input  logic      is_addr,
  input  logic      is_data,
  input  cfg_addr_t a,
  output tgt_e      tgt
);
  logic [NINT-1:0] claim;
  logic [NINT-1:0] impl;

  for (genvar i = 0; i < NINT; i++) begin : g_int
    assign claim[i] = (a.bus == '0) && (a.dev == DEV_W'(i));
    assign impl[i]  = INT_FUNCS[i*NFUNC + int'(a.func)];
  end

  always_comb begin
    tgt = TGT_ONES;
    if (is_addr)                 tgt = TGT_ADDR;
    else if (is_data && a.en) begin
      if (claim[0])              tgt = impl[0] ? TGT_DEV0 : TGT_ONES;
      else if (claim[1])         tgt = impl[1] ? TGT_DEV1 : TGT_ONES;
      else                       tgt = TGT_DOWN;
    end
  end
endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
  import cfg_router_pkg::*;
#(
  parameter int              HAW        = 16,
  parameter logic [HAW-1:0]  ADDR_PORT  = 16'h0CF8,
  parameter logic [HAW-1:0]  DATA_PORT  = 16'h0CFC,
  parameter logic [NFUNC-1:0] DEV0_FUNCS = 8'h01,
  parameter logic [NFUNC-1:0] DEV1_FUNCS = 8'h01
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hst_req,
  input  logic              hst_we,
  input  logic [HAW-3:0]    hst_dw_addr,
  input  logic [BE_W-1:0]   hst_be,
  input  logic [DW-1:0]     hst_wdata,
  output logic              hst_ack,
  output logic [DW-1:0]     hst_rdata,
  output logic              rf0_req,
  output logic              rf1_req,
  output logic              rf_we,
  output logic [FUNC_W-1:0] rf_func,
  output logic [REG_W-1:0]  rf_reg,
  output logic [BE_W-1:0]   rf_be,
  output logic [DW-1:0]     rf_wdata,
  input  logic [DW-1:0]     rf0_rdata,
  input  logic [DW-1:0]     rf1_rdata,
  output logic              ds_req,
  output logic              ds_we,
  output logic              ds_type1,
  output logic [BUS_W-1:0]  ds_bus,
  output logic [DEV_W-1:0]  ds_dev,
  output logic [FUNC_W-1:0] ds_func,
  output logic [REG_W-1:0]  ds_reg,
  output logic [BE_W-1:0]   ds_be,
  output logic [DW-1:0]     ds_wdata,
  input  logic              ds_ack,
  input  logic [DW-1:0]     ds_rdata
);
  localparam logic [HAW-3:0] ADDR_DW = ADDR_PORT[HAW-1:2];
  localparam logic [HAW-3:0] DATA_DW = DATA_PORT[HAW-1:2];
  localparam logic [DW-1:0]  ONES    = '1;

  st_e       st;
  cfg_addr_t cur;
  logic [DW-1:0] addr_view;
  tgt_e      tgt;
  logic      sel1;
  logic      is_addr, is_data, addr_wr;

  assign is_addr = (hst_dw_addr == ADDR_DW);
  assign is_data = (hst_dw_addr == DATA_DW);
  assign addr_wr = hst_req && (st == ST_IDLE) && is_addr && hst_we && (&hst_be);

  cfg_addr_reg u_addr (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (addr_wr),
    .wr_val  ({hst_wdata[31], hst_wdata[23:2]}),
    .cur     (cur),
    .rd_view (addr_view)
  );

  cfg_target_decode #(.INT_FUNCS({DEV1_FUNCS, DEV0_FUNCS})) u_dec (
    .is_addr (is_addr),
    .is_data (is_data),
    .a       (cur),
    .tgt     (tgt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;   sel1 <= 1'b0;
      hst_ack <= 1'b0; hst_rdata <= '0;
      rf0_req <= 1'b0; rf1_req <= 1'b0; rf_we <= 1'b0;
      rf_func <= '0;   rf_reg <= '0;    rf_be <= '0; rf_wdata <= '0;
      ds_req <= 1'b0;  ds_we <= 1'b0;   ds_type1 <= 1'b0;
      ds_bus <= '0;    ds_dev <= '0;    ds_func <= '0; ds_reg <= '0;
      ds_be <= '0;     ds_wdata <= '0;
    end else begin
      hst_ack <= 1'b0;
      rf0_req <= 1'b0;
      rf1_req <= 1'b0;
      case (st)
        ST_IDLE: if (hst_req) begin
          case (tgt)
            TGT_ADDR: begin
              hst_ack   <= 1'b1;
              hst_rdata <= hst_we ? '0 : addr_view;
            end
            TGT_DEV0, TGT_DEV1: begin
              rf0_req  <= (tgt == TGT_DEV0);
              rf1_req  <= (tgt == TGT_DEV1);
              sel1     <= (tgt == TGT_DEV1);
              rf_we    <= hst_we;
              rf_func  <= cur.func;
              rf_reg   <= cur.regn;
              rf_be    <= hst_be;
              rf_wdata <= hst_wdata;
              st       <= ST_RF_ISSUE;
            end
            TGT_DOWN: begin
              ds_req   <= 1'b1;
              ds_we    <= hst_we;
              ds_type1 <= (cur.bus != '0);
              ds_bus   <= cur.bus;
              ds_dev   <= cur.dev;
              ds_func  <= cur.func;
              ds_reg   <= cur.regn;
              ds_be    <= hst_be;
              ds_wdata <= hst_wdata;
              st       <= ST_DS_WAIT;
            end
            default: begin
              hst_ack   <= 1'b1;
              hst_rdata <= hst_we ? '0 : ONES;
            end
          endcase
        end
        ST_RF_ISSUE: st <= ST_RF_CAPT;
        ST_RF_CAPT: begin
          hst_ack   <= 1'b1;
          hst_rdata <= rf_we ? '0 : (sel1 ? rf1_rdata : rf0_rdata);
          st        <= ST_IDLE;
        end
        ST_DS_WAIT: if (ds_ack) begin
          ds_req    <= 1'b0;
          hst_ack   <= 1'b1;
          hst_rdata <= ds_we ? '0 : ds_rdata;
          st        <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R1: a partial write to the address port leaves the register alone
  p_partial_hold_r1: assert property (@(posedge clk) disable iff (rst)
    (hst_req && is_addr && hst_we && !(&hst_be)) |=> $stable(cur));

  // R3: disabled data-port access raises no target request
  p_disabled_quiet_r3: assert property (@(posedge clk) disable iff (rst)
    (hst_req && st == ST_IDLE && is_data && !cur.en) |=> !(rf0_req || rf1_req || ds_req));

  // R6: internal strobes only for implemented functions
  p_impl_func_r6: assert property (@(posedge clk) disable iff (rst)
    (rf0_req |-> DEV0_FUNCS[rf_func]) and (rf1_req |-> DEV1_FUNCS[rf_func]));

  // R7: internal devices on bus 0 are never forwarded
  p_no_int_fwd_r7: assert property (@(posedge clk) disable iff (rst)
    (ds_req && ds_bus == '0) |-> (ds_dev > DEV_W'(1)));

  // R8: forwarded request held stable until acknowledged
  p_ds_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (ds_req && !ds_ack) |=> ds_req && $stable({ds_we, ds_bus, ds_dev, ds_func, ds_reg, ds_be, ds_wdata}));

  // R9: single target, single-cycle acknowledge
  p_one_target_r9: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rf0_req, rf1_req, ds_req}));
  p_ack_pulse_r9: assert property (@(posedge clk) disable iff (rst)
    hst_ack |=> !hst_ack);
endmodule

// File: tb/cfg_access_router_tb.sv
module cfg_access_router_tb_top;
  localparam time CLK_P  = 10ns;
  localparam int  DS_LAT = 2;
  localparam int  NVEC   = 30;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        hst_req = 1'b0, hst_we = 1'b0;
  logic [13:0] hst_dw_addr = '0;
  logic [3:0]  hst_be = '0;
  logic [31:0] hst_wdata = '0;
  logic        hst_ack;
  logic [31:0] hst_rdata;
  logic        rf0_req, rf1_req, rf_we;
  logic [2:0]  rf_func;
  logic [5:0]  rf_reg;
  logic [3:0]  rf_be;
  logic [31:0] rf_wdata;
  logic [31:0] rf0_rdata = '0, rf1_rdata = '0;
  logic        ds_req, ds_we, ds_type1;
  logic [7:0]  ds_bus;
  logic [4:0]  ds_dev;
  logic [2:0]  ds_func;
  logic [5:0]  ds_reg;
  logic [3:0]  ds_be;
  logic [31:0] ds_wdata;
  logic        ds_ack = 1'b0;
  logic [31:0] ds_rdata = '0;

  always #(CLK_P/2) clk = ~clk;

  cfg_access_router dut_i (.*);

  int n_chk = 0, n_err = 0;
  int n_rf0 = 0, n_rf1 = 0, n_ds = 0;

  // register-file models: registered read one cycle after strobe
  logic [31:0] mem0 [512];
  logic [31:0] mem1 [512];
  always @(posedge clk) begin
    if (rf0_req) begin
      n_rf0 <= n_rf0 + 1;
      if (rf_we) begin
        for (int b = 0; b < 4; b++)
          if (rf_be[b]) mem0[{rf_func, rf_reg}][8*b +: 8] <= rf_wdata[8*b +: 8];
      end else rf0_rdata <= mem0[{rf_func, rf_reg}];
    end
    if (rf1_req) begin
      n_rf1 <= n_rf1 + 1;
      if (rf_we) begin
        for (int b = 0; b < 4; b++)
          if (rf_be[b]) mem1[{rf_func, rf_reg}][8*b +: 8] <= rf_wdata[8*b +: 8];
      end else rf1_rdata <= mem1[{rf_func, rf_reg}];
    end
  end

  // downstream model: acknowledges after DS_LAT waiting cycles
  int          ds_wait = 0;
  logic        cap_we, cap_t1;
  logic [3:0]  cap_be;
  logic [31:0] cap_wd;
  logic [7:0]  cap_bus;
  logic [5:0]  cap_reg;
  always @(negedge clk) begin
    ds_ack <= 1'b0;
    if (ds_req && !ds_ack) begin
      if (ds_wait == DS_LAT) begin
        ds_ack   <= 1'b1;
        ds_rdata <= {ds_type1 ? 8'h11 : 8'h00, ds_bus, ds_dev, ds_func, ds_reg, 2'b00};
        cap_we <= ds_we; cap_t1 <= ds_type1; cap_be <= ds_be;
        cap_wd <= ds_wdata; cap_bus <= ds_bus; cap_reg <= ds_reg;
        n_ds    <= n_ds + 1;
        ds_wait <= 0;
      end else ds_wait <= ds_wait + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_io(input logic we, input logic [15:0] addr, input logic [3:0] be,
                         input logic [31:0] wd, output logic [31:0] rd, output int lat);
    @(negedge clk);
    hst_req = 1'b1; hst_we = we; hst_dw_addr = addr[15:2]; hst_be = be; hst_wdata = wd;
    lat = 0;
    do begin
      @(negedge clk);
      hst_req = 1'b0;
      lat++;
    end while (!hst_ack && lat < 64);
    rd = hst_rdata;
  endtask

  // {req tag, we, port, be, wdata, expected rdata}
  localparam logic [88:0] VEC [NVEC] = '{
    {4'd1,  1'b1, 16'h0CF8, 4'hF, 32'h80000000, 32'h0},        // R1 select dev0 f0 r0
    {4'd4,  1'b1, 16'h0CFC, 4'hF, 32'h11223344, 32'h0},        // R4
    {4'd4,  1'b0, 16'h0CFC, 4'hF, 32'h0,        32'h11223344}, // R4
    {4'd1,  1'b1, 16'h0CF8, 4'hF, 32'h80000804, 32'h0},        // R1 dev1 r1
    {4'd4,  1'b1, 16'h0CFC, 4'hF, 32'hAABBCCDD, 32'h0},        // R4
    {4'd4,  1'b0, 16'h0CFC, 4'hF, 32'h0,        32'hAABBCCDD}, // R4
    {4'd1,  1'b1, 16'h0CF8, 4'hF, 32'h80000000, 32'h0},
    {4'd5,  1'b1, 16'h0CFC, 4'h1, 32'h000000EE, 32'h0},        // R5 lane 0 only
    {4'd5,  1'b0, 16'h0CFC, 4'hF, 32'h0,        32'h112233EE}, // R5
    {4'd2,  1'b0, 16'h0CF8, 4'hF, 32'h0,        32'h80000000}, // R2
    {4'd1,  1'b1, 16'h0CF8, 4'h3, 32'h0000FFFF, 32'h0},        // R1 partial
    {4'd1,  1'b0, 16'h0CF8, 4'hF, 32'h0,        32'h80000000}, // R1
    {4'd2,  1'b1, 16'h0CF8, 4'hF, 32'h7F000003, 32'h0},        // R2 reserved bits
    {4'd2,  1'b0, 16'h0CF8, 4'hF, 32'h0,        32'h00000000}, // R2
    {4'd3,  1'b0, 16'h0CFC, 4'hF, 32'h0,        32'hFFFFFFFF}, // R3
    {4'd3,  1'b1, 16'h0CFC, 4'hF, 32'h12345678, 32'h0},        // R3 dropped
    {4'd1,  1'b1, 16'h0CF8, 4'hF, 32'h80000000, 32'h0},
    {4'd3,  1'b0, 16'h0CFC, 4'hF, 32'h0,        32'h112233EE}, // R3
    {4'd1,  1'b1, 16'h0CF8, 4'hF, 32'h80001000, 32'h0},        // bus0 dev2
    {4'd7,  1'b0, 16'h0CFC, 4'hF, 32'h0,        32'h00001000}, // R7 type 0
    {4'd1,  1'b1, 16'h0CF8, 4'hF, 32'h80030010, 32'h0},        // bus3 dev0
    {4'd7,  1'b0, 16'h0CFC, 4'hF, 32'h0,        32'h11030010}, // R7 type 1
    {4'd1,  1'b1, 16'h0CF8, 4'hF, 32'h80050800, 32'h0},        // bus5 dev1
    {4'd7,  1'b0, 16'h0CFC, 4'hF, 32'h0,        32'h11050800}, // R7
    {4'd1,  1'b1, 16'h0CF8, 4'hF, 32'h80000100, 32'h0},        // dev0 f1
    {4'd6,  1'b0, 16'h0CFC, 4'hF, 32'h0,        32'hFFFFFFFF}, // R6
    {4'd10, 1'b0, 16'h0CF4, 4'hF, 32'h0,        32'hFFFFFFFF}, // R10
    {4'd2,  1'b1, 16'h0CF8, 4'hF, 32'hFFFFFFFF, 32'h0},
    {4'd2,  1'b0, 16'h0CF8, 4'hF, 32'h0,        32'h80FFFFFC}, // R2
    {4'd8,  1'b0, 16'h0CFC, 4'hF, 32'h0,        32'h11FFFFFC}  // R8 read data
  };

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_chk++; n_err++;
    $display("FAIL R9 watchdog: actual no completion expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] rd;
    int lat, c0, c1, cd;
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;

    // R11 reset state
    @(negedge clk);
    check("R11 outputs idle", {28'h0, hst_ack, rf0_req, rf1_req, ds_req}, 32'h0);
    host_io(1'b0, 16'h0CF8, 4'hF, 32'h0, rd, lat);
    check("R11 address reg cleared", rd, 32'h0);
    host_io(1'b0, 16'h0CFC, 4'hF, 32'h0, rd, lat);
    check("R11 starts disabled", rd, 32'hFFFFFFFF);

    for (int i = 0; i < NVEC; i++) begin
      host_io(VEC[i][84], VEC[i][83:68], VEC[i][67:64], VEC[i][63:32], rd, lat);
      check($sformatf("R%0d vector %0d", VEC[i][88:85], i), rd, VEC[i][31:0]);
    end

    // R9 latencies
    host_io(1'b1, 16'h0CF8, 4'hF, 32'h80000000, rd, lat);
    check("R9 address-port latency", lat, 1);
    host_io(1'b0, 16'h0CFC, 4'hF, 32'h0, rd, lat);
    check("R9 internal latency", lat, 3);
    host_io(1'b1, 16'h0CF8, 4'hF, 32'h80030010, rd, lat);
    host_io(1'b0, 16'h0CFC, 4'hF, 32'h0, rd, lat);
    check("R8 forwarded latency", lat, DS_LAT + 2);

    // R7 R5 forwarded write payload
    host_io(1'b1, 16'h0CFC, 4'h6, 32'hCAFEF00D, rd, lat);
    check("R7 write flag and type", {30'h0, cap_we, cap_t1}, 32'h3);
    check("R5 forwarded byte enables", {28'h0, cap_be}, 32'h6);
    check("R7 forwarded data", cap_wd, 32'hCAFEF00D);
    check("R7 forwarded bus/reg", {18'h0, cap_bus, cap_reg}, {18'h0, 8'h03, 6'h04});
    check("R10 write ack data zero", rd, 32'h0);

    // R7 bus 0, device 3, function 7, register 2 -> type 0
    host_io(1'b1, 16'h0CF8, 4'hF, 32'h80001F08, rd, lat);
    host_io(1'b0, 16'h0CFC, 4'hF, 32'h0, rd, lat);
    check("R7 type0 fields", rd, 32'h00001F08);

    // R3 no requests while disabled
    host_io(1'b1, 16'h0CF8, 4'hF, 32'h00000800, rd, lat);
    c0 = n_rf0; c1 = n_rf1; cd = n_ds;
    host_io(1'b1, 16'h0CFC, 4'hF, 32'h55555555, rd, lat);
    host_io(1'b0, 16'h0CFC, 4'hF, 32'h0, rd, lat);
    check("R3 disabled read", rd, 32'hFFFFFFFF);
    check("R3 no target request", n_rf0 + n_rf1 + n_ds - c0 - c1 - cd, 0);

    // R6 unimplemented function of device 1
    host_io(1'b1, 16'h0CF8, 4'hF, 32'h80000900, rd, lat);
    c0 = n_rf0; c1 = n_rf1; cd = n_ds;
    host_io(1'b1, 16'h0CFC, 4'hF, 32'h01010101, rd, lat);
    host_io(1'b0, 16'h0CFC, 4'hF, 32'h0, rd, lat);
    check("R6 unimplemented read", rd, 32'hFFFFFFFF);
    check("R6 no target request", n_rf0 + n_rf1 + n_ds - c0 - c1 - cd, 0);

    // R10 write to a foreign port leaves the address register alone
    host_io(1'b1, 16'h0CF4, 4'hF, 32'h00000000, rd, lat);
    host_io(1'b0, 16'h0CF8, 4'hF, 32'h0, rd, lat);
    check("R10 foreign write ignored", rd, 32'h80000900);

    // R4 device 1 register 1 still holds its data
    host_io(1'b1, 16'h0CF8, 4'hF, 32'h80000804, rd, lat);
    host_io(1'b0, 16'h0CFC, 4'hF, 32'h0, rd, lat);
    check("R4 device 1 readback", rd, 32'hAABBCCDD);

    finish_run();
  end
endmodule